// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block caches page translations in a small, fully associative array whose depth is set by a parameter. Each slot holds a virtual page tag, a physical page number, an address-space number, a global flag, per-mode read-enable and write-enable masks, and two fault-on-access flags, one for reads and one for writes. A lookup presents a page number and the current address-space number. The block answers in the same cycle with a hit flag and the whole matching slot. A slot marked global matches under every address-space number.

New translations are written through an insert port. Each insert writes the slot named by a round-robin victim pointer, replaces whatever that slot held, and then moves the pointer on. Three kinds of invalidation are provided: clear everything, drop every non-global slot, or drop the slots that match one address. An index-read port shows the slot under the victim pointer and moves the pointer on only when asked. Permission checking and fault generation are left to the logic that consumes the lookup result.

Top module: `xlate_tlb`

## Requirements
- R1: After reset every slot is invalid and the victim pointer is 0, so `lk_hit` and `ix_valid` are 0 and `ix_word` is all zeros.
- R2: `lk_hit` is 1 exactly when some valid slot has a tag equal to `lk_vpn` and either has its global bit set or stores an address-space number equal to `lk_asn`. The result is combinational on the current contents.
- R3: On a hit, `lk_word` carries the matching slot in this layout, MSB first: tag (VPN_W), physical page (PPN_W), address-space number (ASN_W), global (1), read-enable mask (MODE_W), write-enable mask (MODE_W), fault-on-read (1), fault-on-write (bit 0). `ix_word` uses the same layout.
- R4: An insert writes the slot at the victim pointer with tag `ins_va[VA_W-1:13]` and the supplied fields, marks it valid, replaces any valid contents there, and advances the pointer. The new slot is visible from the next cycle on.
- R5: The victim pointer steps from DEPTH-1 back to 0.
- R6: A flush-all invalidates every slot, clears its contents, and returns the victim pointer to 0.
- R7: A flush-process invalidates every slot whose global bit is 0 and leaves global slots valid and unchanged.
- R8: A flush-address invalidates every valid slot whose tag equals `fl_va[VA_W-1:13]` and that is global or holds `fl_asn`. All other slots are unaffected.
- R9: `ix_valid` and `ix_word` show the slot at the victim pointer. The pointer moves on when `ix_adv` is 1 and holds when it is 0 with no insert. An insert and an advance in the same cycle move it by one step.
- R10: When an insert coincides with any flush, the flush is applied and the insert is ignored. No slot is written and the pointer does not move for it.
- R11: When several slots hit, the one with the lowest index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_asn | input | ASN_W | Current address-space number for the lookup |
| lk_hit | output | 1 | Lookup found a matching slot |
| lk_word | output | ENT_W | Matching slot contents (R3 layout) |
| ins_en | input | 1 | Insert a translation at the victim pointer |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_asn | input | ASN_W | Address-space number to store |
| ins_glob | input | 1 | Global flag to store |
| ins_rd_en | input | MODE_W | Per-mode read-enable mask to store |
| ins_wr_en | input | MODE_W | Per-mode write-enable mask to store |
| ins_flt_rd | input | 1 | Fault-on-read flag to store |
| ins_flt_wr | input | 1 | Fault-on-write flag to store |
| fl_all | input | 1 | Invalidate every slot and reset the pointer |
| fl_proc | input | 1 | Invalidate every non-global slot |
| fl_addr | input | 1 | Invalidate the slots matching `fl_va` / `fl_asn` |
| fl_va | input | VA_W | Address for the address flush |
| fl_asn | input | ASN_W | Address-space number for the address flush |
| ix_adv | input | 1 | Advance the victim pointer |
| ix_valid | output | 1 | Slot at the victim pointer is valid |
| ix_word | output | ENT_W | Slot at the victim pointer (R3 layout) |

## Verification
Lookups are made against slots that differ only in address-space number, only in global flag, or only in tag, so that each term of the match condition is tested on its own. Duplicate tags placed in several slots separate a lowest-index choice from any other choice. Filling past the depth shows the pointer wrap and overwrite of valid data, and the index port reveals the pointer position. Each flush kind is applied to a mix of global and per-process slots, and also together with an insert, so that the scope of each flush and its priority over the insert can be seen. A long mixed random phase over a small tag and address-space space then gives many coincident hits and flushes.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   parameter int unsigned VA_W       = 43;
   parameter int unsigned PAGE_SHIFT = 13;
   parameter int unsigned PPN_W      = 28;
   parameter int unsigned ASN_W      = 8;
   parameter int unsigned MODE_W     = 4;

   localparam int unsigned VPN_W = VA_W - PAGE_SHIFT;

   typedef struct packed {
      logic [VPN_W-1:0]  tag;
      logic [PPN_W-1:0]  ppn;
      logic [ASN_W-1:0]  asn;
      logic              glob;
      logic [MODE_W-1:0] rd_en;
      logic [MODE_W-1:0] wr_en;
      logic              flt_rd;
      logic              flt_wr;
   } tlb_ent_t;

   localparam int unsigned ENT_W = $bits(tlb_ent_t);
endpackage

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
   parameter int unsigned DEPTH = 48,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_cmp
         assign nxt = (ptr == IDX_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= '0;
      else if (clr)  ptr <= '0;
      else if (step) ptr <= nxt;
   end
endmodule

// File: rtl/tlbx_store.sv
module tlbx_store
   import tlbx_pkg::*;
#(
   parameter int unsigned DEPTH = 48,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_go,
   input  logic [IDX_W-1:0] wr_idx,
   input  tlb_ent_t         wr_ent,
   input  logic             fl_all,
   input  logic             fl_proc,
   input  logic             fl_addr,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [ASN_W-1:0] fl_asn,
   output logic [DEPTH-1:0] valid,
   output tlb_ent_t         ents [DEPTH]
);
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic kill_proc, kill_addr, sel;

         assign kill_proc = fl_proc && !ents[i].glob;
         assign kill_addr = fl_addr && (ents[i].tag == fl_vpn) &&
                            (ents[i].glob || (ents[i].asn == fl_asn));
         assign sel       = wr_go && (wr_idx == IDX_W'(i));

         always_ff @(posedge clk) begin
            if (!rst_n || fl_all) begin
               valid[i] <= 1'b0;
               ents[i]  <= '0;
            end else if (valid[i] && (kill_proc || kill_addr)) begin
               valid[i] <= 1'b0;
            end else if (sel) begin
               valid[i] <= 1'b1;
               ents[i]  <= wr_ent;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
   import tlbx_pkg::*;
#(
   parameter int unsigned DEPTH = 48
) (
   input  logic [DEPTH-1:0] valid,
   input  tlb_ent_t         ents [DEPTH],
   input  logic [VPN_W-1:0] key_vpn,
   input  logic [ASN_W-1:0] key_asn,
   output logic             hit,
   output tlb_ent_t         hit_ent
);
   logic [DEPTH-1:0] hv;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
         assign hv[i] = valid[i] && (ents[i].tag == key_vpn) &&
                        (ents[i].glob || (ents[i].asn == key_asn));
      end
   endgenerate

   // Scan downward so the lowest matching index is the last one written.
   always_comb begin
      hit     = 1'b0;
      hit_ent = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit     = 1'b1;
            hit_ent = ents[i];
         end
      end
   end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
   import tlbx_pkg::*;
#(
   parameter int unsigned DEPTH = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [ENT_W-1:0]  lk_word,
   input  logic              ins_en,
   input  logic [VA_W-1:0]   ins_va,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [ASN_W-1:0]  ins_asn,
   input  logic              ins_glob,
   input  logic [MODE_W-1:0] ins_rd_en,
   input  logic [MODE_W-1:0] ins_wr_en,
   input  logic              ins_flt_rd,
   input  logic              ins_flt_wr,
   input  logic              fl_all,
   input  logic              fl_proc,
   input  logic              fl_addr,
   input  logic [VA_W-1:0]   fl_va,
   input  logic [ASN_W-1:0]  fl_asn,
   input  logic              ix_adv,
   output logic              ix_valid,
   output logic [ENT_W-1:0]  ix_word
);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("xlate_tlb: DEPTH must be at least 2");
      end
      if (PAGE_SHIFT >= VA_W) begin : g_bad_shift
         $error("xlate_tlb: page offset must be narrower than the address");
      end
   endgenerate

   logic             any_fl, ins_go, ptr_step;
   logic [IDX_W-1:0] vict_ptr;
   logic [DEPTH-1:0] slot_v;
   tlb_ent_t         slot_e [DEPTH];
   tlb_ent_t         new_ent, hit_ent;

   assign any_fl   = fl_all || fl_proc || fl_addr;
   assign ins_go   = ins_en && !any_fl;
   assign ptr_step = ins_go || ix_adv;

   always_comb begin
      new_ent.tag    = ins_va[VA_W-1:PAGE_SHIFT];
      new_ent.ppn    = ins_ppn;
      new_ent.asn    = ins_asn;
      new_ent.glob   = ins_glob;
      new_ent.rd_en  = ins_rd_en;
      new_ent.wr_en  = ins_wr_en;
      new_ent.flt_rd = ins_flt_rd;
      new_ent.flt_wr = ins_flt_wr;
   end

   tlbx_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (fl_all),
      .step (ptr_step),
      .ptr  (vict_ptr)
   );

   tlbx_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_go  (ins_go),
      .wr_idx (vict_ptr),
      .wr_ent (new_ent),
      .fl_all (fl_all),
      .fl_proc(fl_proc),
      .fl_addr(fl_addr),
      .fl_vpn (fl_va[VA_W-1:PAGE_SHIFT]),
      .fl_asn (fl_asn),
      .valid  (slot_v),
      .ents   (slot_e)
   );

   tlbx_match #(.DEPTH(DEPTH)) u_match (
      .valid  (slot_v),
      .ents   (slot_e),
      .key_vpn(lk_vpn),
      .key_asn(lk_asn),
      .hit    (lk_hit),
      .hit_ent(hit_ent)
   );

   assign lk_word  = hit_ent;
   assign ix_valid = slot_v[vict_ptr];
   assign ix_word  = slot_e[vict_ptr];
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
   import tlbx_pkg::*;
#(
   parameter int unsigned DEPTH = 48,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fl_all,
   input logic             fl_proc,
   input logic             lk_hit,
   input logic [ENT_W-1:0] lk_word,
   input logic [VPN_W-1:0] lk_vpn,
   input logic [ASN_W-1:0] lk_asn,
   input logic             ix_valid,
   input logic [IDX_W-1:0] ptr
);
   tlb_ent_t hw;
   assign hw = tlb_ent_t'(lk_word);

   // R2
   hit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (hw.tag == lk_vpn) && (hw.glob || (hw.asn == lk_asn)));

   // R5
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < int'(DEPTH));

   // R6
   flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_all |=> (!lk_hit && !ix_valid));

   // R6
   flush_all_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_all |=> (ptr == '0));

   // R7
   flush_proc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_proc |=> (!lk_hit || hw.glob));
endmodule

bind xlate_tlb tlbx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fl_all  (fl_all),
   .fl_proc (fl_proc),
   .lk_hit  (lk_hit),
   .lk_word (lk_word),
   .lk_vpn  (lk_vpn),
   .lk_asn  (lk_asn),
   .ix_valid(ix_valid),
   .ptr     (vict_ptr)
);

// File: tb/xlate_tlb_bench.sv
module xlate_tlb_bench;
   import tlbx_pkg::*;

   localparam int D      = 48;
   localparam int P_GL   = 2 + 2 * MODE_W;
   localparam int P_ASN  = P_GL + 1;
   localparam int P_PPN  = P_ASN + ASN_W;
   localparam int P_TAG  = P_PPN + PPN_W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic [VPN_W-1:0]  lk_vpn;
   logic [ASN_W-1:0]  lk_asn;
   logic              lk_hit;
   logic [ENT_W-1:0]  lk_word;
   logic              ins_en;
   logic [VA_W-1:0]   ins_va;
   logic [PPN_W-1:0]  ins_ppn;
   logic [ASN_W-1:0]  ins_asn;
   logic              ins_glob;
   logic [MODE_W-1:0] ins_rd_en, ins_wr_en;
   logic              ins_flt_rd, ins_flt_wr;
   logic              fl_all, fl_proc, fl_addr;
   logic [VA_W-1:0]   fl_va;
   logic [ASN_W-1:0]  fl_asn;
   logic              ix_adv;
   logic              ix_valid;
   logic [ENT_W-1:0]  ix_word;

   xlate_tlb #(.DEPTH(D)) u_xlate_tlb (.*);

   int n_cmp = 0;
   int n_bad = 0;
   bit               m_v [D];
   logic [ENT_W-1:0] m_w [D];
   int               m_ptr = 0;

   task automatic check(string rq, string what, logic [ENT_W-1:0] act, logic [ENT_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < D; i++) begin m_v[i] = 1'b0; m_w[i] = '0; end
      m_ptr = 0;
   endtask

   // Compare this cycle's outputs, then advance the model across the edge.
   task automatic cyc(string rq);
      bit               e_hit;
      logic [ENT_W-1:0] e_w, w;
      bit               anyf, kill;
      #1;
      e_hit = 1'b0;
      e_w   = '0;
      for (int i = 0; i < D; i++) begin
         w = m_w[i];
         if (!e_hit && m_v[i] && w[P_TAG +: VPN_W] == lk_vpn &&
             (w[P_GL] || w[P_ASN +: ASN_W] == lk_asn)) begin
            e_hit = 1'b1;
            e_w   = w;
         end
      end
      check(rq, "lk_hit", ENT_W'(lk_hit), ENT_W'(e_hit));
      if (e_hit) check(rq, "lk_word", lk_word, e_w);
      check(rq, "ix_valid", ENT_W'(ix_valid), ENT_W'(m_v[m_ptr]));
      if (!rst_n) check(rq, "ix_word", ix_word, '0);
      else if (m_v[m_ptr]) check(rq, "ix_word", ix_word, m_w[m_ptr]);

      if (!rst_n || fl_all) begin
         model_clear();
      end else begin
         anyf = fl_proc || fl_addr;
         for (int i = 0; i < D; i++) begin
            w    = m_w[i];
            kill = (fl_proc && !w[P_GL]) ||
                   (fl_addr && w[P_TAG +: VPN_W] == fl_va[VA_W-1:PAGE_SHIFT] &&
                    (w[P_GL] || w[P_ASN +: ASN_W] == fl_asn));
            if (m_v[i] && kill) m_v[i] = 1'b0;
         end
         if (ins_en && !anyf) begin
            m_v[m_ptr] = 1'b1;
            m_w[m_ptr] = {ins_va[VA_W-1:PAGE_SHIFT], ins_ppn, ins_asn, ins_glob,
                          ins_rd_en, ins_wr_en, ins_flt_rd, ins_flt_wr};
         end
         if ((ins_en && !anyf) || ix_adv) m_ptr = (m_ptr + 1) % D;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ins_en = 0; fl_all = 0; fl_proc = 0; fl_addr = 0; ix_adv = 0;
   endtask

   task automatic put(int vpn, int ppn, int asn, bit g, string rq);
      ins_en     = 1;
      ins_va     = {VPN_W'(vpn), PAGE_SHIFT'($urandom)};
      ins_ppn    = PPN_W'(ppn);
      ins_asn    = ASN_W'(asn);
      ins_glob   = g;
      ins_rd_en  = MODE_W'($urandom);
      ins_wr_en  = MODE_W'($urandom);
      ins_flt_rd = 1'($urandom);
      ins_flt_wr = 1'($urandom);
      cyc(rq);
      ins_en = 0;
   endtask

   task automatic probe(int vpn, int asn, string rq);
      lk_vpn = VPN_W'(vpn);
      lk_asn = ASN_W'(asn);
      cyc(rq);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_clear();
      rst_n = 0; idle();
      lk_vpn = '0; lk_asn = '0; ins_va = '0; ins_ppn = '0; ins_asn = '0;
      ins_glob = 0; ins_rd_en = '0; ins_wr_en = '0; ins_flt_rd = 0; ins_flt_wr = 0;
      fl_va = '0; fl_asn = '0;
      @(negedge clk);
      cyc("R1"); cyc("R1");
      rst_n = 1;
      probe(0, 0, "R1"); probe(5, 3, "R1");

      // R2 / R3 / R4: slot0 vpn5 asn3 private, slot1 vpn6 global asn9
      lk_vpn = 5; lk_asn = 3;
      put(5, 'h111, 3, 0, "R4");         // same-cycle lookup misses
      put(6, 'h222, 9, 1, "R4");
      probe(5, 3, "R2"); probe(5, 4, "R2"); probe(6, 0, "R2");
      probe(6, 9, "R3"); probe(7, 3, "R2");

      // R11: duplicates of vpn 5
      put(5, 'h333, 4, 0, "R11");        // slot2
      put(5, 'h444, 7, 1, "R11");        // slot3 global
      probe(5, 4, "R11"); probe(5, 3, "R11"); probe(5, 9, "R11");

      // R9: pointer holds without advance, then moves on
      ix_adv = 0; cyc("R9"); cyc("R9");
      ix_adv = 1; cyc("R9"); ix_adv = 0; cyc("R9");

      // R5: fill past the depth so the pointer wraps to 0
      for (int i = 0; i < D; i++) put(100 + i, i, i % 5, i[0], "R5");
      cyc("R5");
      // R4: overwrite valid slots
      put(200, 'h555, 2, 0, "R4");
      probe(200, 2, "R4"); probe(101, 1, "R4");
      ix_adv = 1; ins_en = 1; ins_va = {VPN_W'(201), PAGE_SHIFT'(0)}; cyc("R9");
      idle(); cyc("R9");

      // R7: process flush
      fl_proc = 1; cyc("R7"); idle();
      for (int v = 100; v < 108; v++) probe(v, v % 5, "R7");
      probe(5, 3, "R7"); probe(6, 0, "R7");

      // R8: address flush, global and private targets
      fl_addr = 1; fl_va = {VPN_W'(101), PAGE_SHIFT'(0)}; fl_asn = 0; cyc("R8"); idle();
      probe(101, 1, "R8"); probe(103, 3, "R8");
      put(300, 1, 6, 0, "R8"); put(300, 2, 5, 0, "R8");
      fl_addr = 1; fl_va = {VPN_W'(300), PAGE_SHIFT'(0)}; fl_asn = 6; cyc("R8"); idle();
      probe(300, 6, "R8"); probe(300, 5, "R8");

      // R10: insert coinciding with a flush is dropped
      fl_addr = 1; fl_va = {VPN_W'(999), PAGE_SHIFT'(0)};
      put(400, 7, 1, 1, "R10"); idle();
      probe(400, 1, "R10"); cyc("R10");
      fl_proc = 1; put(401, 7, 1, 1, "R10"); idle(); probe(401, 1, "R10");

      // R6: flush all
      fl_all = 1; ix_adv = 1; put(402, 1, 1, 1, "R6"); idle();
      probe(105, 0, "R6"); probe(103, 3, "R6"); cyc("R6");

      // Mixed random traffic over a small key space
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         idle();
         if (r < 30) begin
            ins_en = 1;
            ins_va = {VPN_W'($urandom_range(0, 7)), PAGE_SHIFT'($urandom)};
            ins_ppn = PPN_W'($urandom); ins_asn = ASN_W'($urandom_range(0, 3));
            ins_glob = ($urandom_range(0, 3) == 0);
            ins_rd_en = MODE_W'($urandom); ins_wr_en = MODE_W'($urandom);
            ins_flt_rd = 1'($urandom); ins_flt_wr = 1'($urandom);
         end
         fl_all  = ($urandom_range(0, 99) == 0);
         fl_proc = ($urandom_range(0, 99) < 3);
         fl_addr = ($urandom_range(0, 99) < 5);
         fl_va   = {VPN_W'($urandom_range(0, 7)), PAGE_SHIFT'($urandom)};
         fl_asn  = ASN_W'($urandom_range(0, 3));
         ix_adv  = ($urandom_range(0, 4) == 0);
         lk_vpn  = VPN_W'($urandom_range(0, 7));
         lk_asn  = ASN_W'($urandom_range(0, 3));
         cyc("R2");
      end
      idle();
      cyc("R3");
      finish_run();
   end
endmodule